// File: doc/BRIEF.md
# SDRAM Refresh Scheduler

This block keeps a synchronous DRAM refreshed without software help. A free-running interval timer produces one refresh "debt" every `REF_INTERVAL` clocks; the default of 1040 clocks at 133 MHz keeps 8192 rows inside a 64 ms retention window. Debts pile up in a small saturating counter while the command arbiter is busy with traffic. The block asks the arbiter for a slot. Once a slot is granted, or once the debt reaches its ceiling and the request turns urgent, the block takes the command pins. It closes any open bank with a precharge-all command, waits until the bank tracker reports every bank precharged, and then issues an auto-refresh command.

The same path handles low power. A sleep request drives the refresh command with the clock enable dropped in the same cycle, which places the memory in self refresh. While the memory sleeps, the pins show a deselect and the interval timer is held at zero. A wake request raises the clock enable with a no-operation command. Commands are then held off for one row cycle time, after which one auto refresh is issued without waiting for a grant.

The arbiter must leave the command pins alone while `sched_busy` is high. After every auto refresh, `sched_busy` stays high for `TRC_CYC` cycles so that the refresh cycle time is met.

Top module: `sdram_refresh_sched`

## Requirements
- R1: While reset is held and in the first cycle after it, the pins carry a no-operation code (chip select low; row strobe, column strobe and write enable high; A10 low) with the clock enable high, and `ref_req`, `ref_urgent` and `sched_busy` are all low.
- R2: `ref_req` first rises exactly `REF_INTERVAL` clocks after reset is released, and again `REF_INTERVAL` clocks after the sample that shows the self-refresh exit. Each further interval adds one owed refresh.
- R3: A command is issued from the idle state only in the cycle after `arb_grant` is high or `ref_urgent` is high. `ref_urgent` is high exactly when the owed count equals `MAX_OWED`.
- R4: When a refresh is owed, a grant arrives and `banks_idle` is high, the next cycle carries the auto-refresh code (chip select, row strobe and column strobe low; write enable high) with the clock enable high. That refresh removes one owed refresh.
- R5: `sched_busy` is high for exactly `TRC_CYC` consecutive cycles that begin with the auto-refresh cycle. The cycle after that it is low, unless a new command has started.
- R6: A granted refresh or sleep request made while `banks_idle` is low issues precharge-all instead (chip select, row strobe and write enable low; column strobe high; A10 high).
- R7: After a precharge-all, no refresh is issued while `banks_idle` stays low. The pins carry a no-operation code and `sched_busy` stays high. The refresh follows in the cycle after `banks_idle` is seen high.
- R8: Self-refresh entry drives the auto-refresh code in the same cycle that the clock enable falls. Entry needs `sleep_req` together with a grant and idle banks, and it clears every owed refresh.
- R9: While in self refresh, the clock enable stays low, the pins carry a deselect (chip select high), and `ref_req` and `ref_urgent` stay low, however many intervals pass.
- R10: A wake request raises the clock enable with a no-operation code in the next cycle. The no-operation code is held with `sched_busy` high for `TRC_CYC` cycles in total, and one auto refresh follows without any grant.
- R11: The owed count saturates at `MAX_OWED`. After a long stall, clearing the debt takes exactly `MAX_OWED` refreshes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every input is sampled on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| banks_idle | input | 1 | High when the bank tracker reports every bank precharged |
| arb_grant | input | 1 | Command slot granted by the arbiter |
| sleep_req | input | 1 | Request to enter self refresh |
| wake_req | input | 1 | Request to leave self refresh |
| ref_req | output | 1 | Refresh or sleep is pending and the scheduler is idle |
| ref_urgent | output | 1 | Owed count at its ceiling; the scheduler will take the pins without a grant |
| sched_busy | output | 1 | Scheduler owns the command pins; the arbiter must not issue |
| sdr_cs_n | output | 1 | Chip select, active low |
| sdr_ras_n | output | 1 | Row strobe, active low |
| sdr_cas_n | output | 1 | Column strobe, active low |
| sdr_we_n | output | 1 | Write enable, active low |
| sdr_a10 | output | 1 | Address bit 10, high selects all banks for precharge |
| sdr_cke | output | 1 | Clock enable |

## Verification
A wrong owed count shows at the ports within one interval. Either `ref_urgent` rises on the wrong tick, or the number of refreshes needed to drop `ref_req` after a stall is not `MAX_OWED`. A wrong hold counter changes the length of the `sched_busy` window, and that shows in the cycle right after the refresh or wake. A wrong state on the self-refresh path shows at once as a clock enable or chip select that does not match the sleep/wake sequence.

// File: rtl/sdram_refresh_pkg.sv
// Shared types for the refresh scheduler: command pin bundle, fixed command
// codes and the controller state encoding.
package sdram_refresh_pkg;

    // Command pins in the order chip select, row strobe, column strobe,
    // write enable, A10.
    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic a10;
    } sdr_pins_t;

    localparam sdr_pins_t PINS_NOP   = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, a10: 1'b0};
    localparam sdr_pins_t PINS_DESEL = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, a10: 1'b0};
    localparam sdr_pins_t PINS_REF   = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, a10: 1'b0};
    localparam sdr_pins_t PINS_PREA  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0, a10: 1'b1};

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,  // pins free for the arbiter
        ST_PREWAIT = 3'd1,  // precharge-all sent, waiting for idle banks
        ST_RFC     = 3'd2,  // refresh cycle time hold
        ST_SR      = 3'd3,  // memory in self refresh
        ST_XWAIT   = 3'd4   // hold after self-refresh exit
    } ref_state_t;

endpackage

// File: rtl/ref_interval_timer.sv
// Interval timer: emits a one-cycle tick every INTERVAL clocks.
// Assumes INTERVAL >= 2. A high clear holds the count at zero and
// suppresses the tick, so counting resumes from zero when clear drops.
module ref_interval_timer #(
    parameter int INTERVAL = 1040
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic tick
);
    localparam int CW = $clog2(INTERVAL);
    localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

    logic [CW-1:0] cnt;

    // Wrapping cycle counter, reset by rst_n or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Tick on the final count of each interval.
    always_comb begin
        tick = !clear && (cnt == LAST);
    end
endmodule

// File: rtl/ref_owed_counter.sv
// Owed-refresh counter: adds one per timer tick and removes one per
// issued auto refresh. Saturates at MAX_OWED and clears on self-refresh entry.
// Assumes MAX_OWED >= 1.
module ref_owed_counter #(
    parameter int MAX_OWED = 8,
    localparam int OW = $clog2(MAX_OWED + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          dec,
    input  logic          clr,
    output logic [OW-1:0] owed,
    output logic          owed_nz,
    output logic          urgent
);
    localparam logic [OW-1:0] CEIL = OW'(MAX_OWED);

    // Debt update with clear priority and saturation at the ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            owed <= '0;
        end else begin
            unique case ({tick, dec && (owed != '0)})
                2'b10:   owed <= (owed == CEIL) ? owed : owed + 1'b1;
                2'b01:   owed <= owed - 1'b1;
                default: owed <= owed;
            endcase
        end
    end

    // Flags decoded from the count for the request logic.
    always_comb begin
        owed_nz = (owed != '0);
        urgent  = (owed == CEIL);
    end
endmodule

// File: rtl/ref_cmd_fsm.sv
// Command sequencer: decides when to precharge, refresh, enter or leave
// self refresh, drives registered command pins and the clock enable, and
// times the refresh cycle hold. Assumes TRC_CYC >= 1 and that banks_idle
// reflects precharges the sequencer issues.
module ref_cmd_fsm
    import sdram_refresh_pkg::*;
#(
    parameter int TRC_CYC = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       banks_idle,
    input  logic       grant,
    input  logic       sleep_req,
    input  logic       wake_req,
    input  logic       owed_nz,
    input  logic       urgent,
    output sdr_pins_t  pins,
    output logic       cke,
    output ref_state_t st,
    output logic       dec_owed,
    output logic       clr_owed
);
    localparam int TW = (TRC_CYC > 1) ? $clog2(TRC_CYC) : 1;
    localparam logic [TW-1:0] HOLD_LAST = TW'(TRC_CYC - 1);

    logic [TW-1:0] hold;
    logic          want;
    logic          may_go;
    logic          do_sr;
    logic          do_ref;

    // Decisions taken at the coming edge, shared by state and debt updates.
    always_comb begin
        want   = sleep_req || owed_nz;
        may_go = grant || urgent;
        do_sr  = ((st == ST_IDLE && may_go) || st == ST_PREWAIT) && banks_idle && sleep_req;
        do_ref = (((st == ST_IDLE && may_go && want) || st == ST_PREWAIT) && banks_idle && !sleep_req)
               || (st == ST_XWAIT && hold == '0);
        dec_owed = do_ref && (st != ST_XWAIT);
        clr_owed = do_sr;
    end

    // State, hold counter, pin and clock-enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            hold <= '0;
            pins <= PINS_NOP;
            cke  <= 1'b1;
        end else begin
            pins <= PINS_NOP;
            unique case (st)
                ST_IDLE: begin
                    if (want && may_go) begin
                        if (!banks_idle) begin
                            pins <= PINS_PREA;
                            st   <= ST_PREWAIT;
                        end else if (do_sr) begin
                            pins <= PINS_REF;
                            cke  <= 1'b0;
                            st   <= ST_SR;
                        end else begin
                            pins <= PINS_REF;
                            hold <= HOLD_LAST;
                            st   <= ST_RFC;
                        end
                    end
                end
                ST_PREWAIT: begin
                    if (do_sr) begin
                        pins <= PINS_REF;
                        cke  <= 1'b0;
                        st   <= ST_SR;
                    end else if (do_ref) begin
                        pins <= PINS_REF;
                        hold <= HOLD_LAST;
                        st   <= ST_RFC;
                    end
                end
                ST_RFC: begin
                    if (hold == '0) begin
                        st <= ST_IDLE;
                    end else begin
                        hold <= hold - 1'b1;
                    end
                end
                ST_SR: begin
                    if (wake_req) begin
                        cke  <= 1'b1;
                        hold <= HOLD_LAST;
                        st   <= ST_XWAIT;
                    end else begin
                        pins <= PINS_DESEL;
                    end
                end
                ST_XWAIT: begin
                    if (hold == '0) begin
                        pins <= PINS_REF;
                        hold <= HOLD_LAST;
                        st   <= ST_RFC;
                    end else begin
                        hold <= hold - 1'b1;
                    end
                end
                default: begin
                    st <= ST_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/sdram_refresh_sched.sv
// Refresh scheduler top: ties the interval timer, the owed counter and the
// command sequencer together and exposes the arbiter handshake and pins.
// Assumes the arbiter yields the pins while sched_busy is high.
module sdram_refresh_sched
    import sdram_refresh_pkg::*;
#(
    parameter int REF_INTERVAL = 1040,
    parameter int MAX_OWED     = 8,
    parameter int TRC_CYC      = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic banks_idle,
    input  logic arb_grant,
    input  logic sleep_req,
    input  logic wake_req,
    output logic ref_req,
    output logic ref_urgent,
    output logic sched_busy,
    output logic sdr_cs_n,
    output logic sdr_ras_n,
    output logic sdr_cas_n,
    output logic sdr_we_n,
    output logic sdr_a10,
    output logic sdr_cke
);
    localparam int OW = $clog2(MAX_OWED + 1);

    logic          tick;
    logic          dec_owed;
    logic          clr_owed;
    logic          owed_nz;
    logic [OW-1:0] owed_cnt;
    ref_state_t    fsm_state;
    sdr_pins_t     pins;

    ref_interval_timer #(.INTERVAL(REF_INTERVAL)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (fsm_state == ST_SR),
        .tick  (tick)
    );

    ref_owed_counter #(.MAX_OWED(MAX_OWED)) u_owed (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .dec     (dec_owed),
        .clr     (clr_owed),
        .owed    (owed_cnt),
        .owed_nz (owed_nz),
        .urgent  (ref_urgent)
    );

    ref_cmd_fsm #(.TRC_CYC(TRC_CYC)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .banks_idle (banks_idle),
        .grant      (arb_grant),
        .sleep_req  (sleep_req),
        .wake_req   (wake_req),
        .owed_nz    (owed_nz),
        .urgent     (ref_urgent),
        .pins       (pins),
        .cke        (sdr_cke),
        .st         (fsm_state),
        .dec_owed   (dec_owed),
        .clr_owed   (clr_owed)
    );

    // Handshake outputs and pin fan-out.
    always_comb begin
        ref_req    = (fsm_state == ST_IDLE) && (owed_nz || sleep_req);
        sched_busy = (fsm_state != ST_IDLE);
        sdr_cs_n   = pins.cs_n;
        sdr_ras_n  = pins.ras_n;
        sdr_cas_n  = pins.cas_n;
        sdr_we_n   = pins.we_n;
        sdr_a10    = pins.a10;
    end
endmodule

// File: rtl/sdram_refresh_sched_chk.sv
// Checker for the refresh scheduler, attached by bind. Relates the pins,
// the handshake and the sequencer state over time.
module sdram_refresh_sched_chk
    import sdram_refresh_pkg::*;
#(
    parameter int MAX_OWED = 8,
    parameter int OW       = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          banks_idle,
    input logic          arb_grant,
    input logic          ref_urgent,
    input logic          sched_busy,
    input logic          sdr_cs_n,
    input logic          sdr_ras_n,
    input logic          sdr_cas_n,
    input logic          sdr_we_n,
    input logic          sdr_a10,
    input logic          sdr_cke,
    input ref_state_t    fsm_state,
    input logic [OW-1:0] owed_cnt
);
    logic is_ref;
    logic is_prea;
    logic is_act;

    // Decode of the command on the pins.
    always_comb begin
        is_ref  = !sdr_cs_n && !sdr_ras_n && !sdr_cas_n && sdr_we_n;
        is_prea = !sdr_cs_n && !sdr_ras_n && sdr_cas_n && !sdr_we_n;
        is_act  = !sdr_cs_n && !(sdr_ras_n && sdr_cas_n && sdr_we_n);
    end

    AST_GRANT_BEFORE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (is_act && $past(fsm_state) == ST_IDLE) |-> $past(arb_grant || ref_urgent)); // R3
    AST_REF_ON_IDLE_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ref && $past(fsm_state) != ST_XWAIT) |-> $past(banks_idle)); // R7
    AST_PREA_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
        is_prea |-> sdr_a10); // R6
    AST_CKE_FALL_WITH_REF: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sdr_cke) |-> is_ref); // R8
    AST_SR_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!sdr_cke && $past(!sdr_cke)) |-> sdr_cs_n); // R9
    AST_REF_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        is_ref |-> sched_busy); // R5
    AST_OWED_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
        owed_cnt <= OW'(MAX_OWED)); // R11
endmodule

bind sdram_refresh_sched sdram_refresh_sched_chk #(.MAX_OWED(MAX_OWED), .OW(OW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .banks_idle (banks_idle),
    .arb_grant  (arb_grant),
    .ref_urgent (ref_urgent),
    .sched_busy (sched_busy),
    .sdr_cs_n   (sdr_cs_n),
    .sdr_ras_n  (sdr_ras_n),
    .sdr_cas_n  (sdr_cas_n),
    .sdr_we_n   (sdr_we_n),
    .sdr_a10    (sdr_a10),
    .sdr_cke    (sdr_cke),
    .fsm_state  (fsm_state),
    .owed_cnt   (owed_cnt)
);

// File: tb/sdram_refresh_sched_bench.sv
module sdram_refresh_sched_bench;
    localparam int IV   = 40;
    localparam int MAXO = 3;
    localparam int TRC  = 4;

    localparam logic [4:0] P_NOP   = 5'b01110;
    localparam logic [4:0] P_DESEL = 5'b11110;
    localparam logic [4:0] P_REF   = 5'b00010;
    localparam logic [4:0] P_PREA  = 5'b00101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic banks_idle = 1'b1;
    logic arb_grant = 1'b0;
    logic sleep_req = 1'b0;
    logic wake_req = 1'b0;
    logic ref_req, ref_urgent, sched_busy;
    logic sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n, sdr_a10, sdr_cke;

    int total = 0;
    int bad = 0;
    int pc = 0;

    always #2 clk = ~clk;

    sdram_refresh_sched #(.REF_INTERVAL(IV), .MAX_OWED(MAXO), .TRC_CYC(TRC)) u_sdram_refresh_sched (
        .clk(clk), .rst_n(rst_n), .banks_idle(banks_idle), .arb_grant(arb_grant),
        .sleep_req(sleep_req), .wake_req(wake_req), .ref_req(ref_req),
        .ref_urgent(ref_urgent), .sched_busy(sched_busy), .sdr_cs_n(sdr_cs_n),
        .sdr_ras_n(sdr_ras_n), .sdr_cas_n(sdr_cas_n), .sdr_we_n(sdr_we_n),
        .sdr_a10(sdr_a10), .sdr_cke(sdr_cke)
    );

    function automatic logic [4:0] pins();
        return {sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n, sdr_a10};
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Advance one clock; outputs are sampled and inputs driven at the falling edge.
    task automatic step();
        @(negedge clk);
        pc++;
    endtask

    task automatic wait_req(input int limit);
        for (int i = 0; i < limit && !ref_req; i++) step();
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        int first_req;
        int nbad;
        int nref;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 pins", int'(pins()), int'(P_NOP));
        chk("R1 cke", int'(sdr_cke), 1);
        chk("R1 req/urg/busy", int'({ref_req, ref_urgent, sched_busy}), 0);
        rst_n = 1'b1;
        pc = 0;
        step();
        chk("R1 first cycle", int'({pins(), sdr_cke, ref_req, sched_busy}), int'({P_NOP, 3'b100}));

        // R2 / R3: debt accrues without grant; urgent at the ceiling
        first_req = -1;
        nbad = 0;
        while (!ref_urgent && pc < 5 * IV) begin
            if (ref_req && first_req < 0) first_req = pc;
            if (pins() != P_NOP) nbad++;
            step();
        end
        chk("R2 first request cycle", first_req, IV);
        chk("R3 urgent cycle", pc, MAXO * IV);
        chk("R3 no command without grant", nbad, 0);

        // R4 / R5: urgent refresh taken without grant, busy window
        step();
        chk("R4 urgent refresh code", int'({pins(), sdr_cke}), int'({P_REF, 1'b1}));
        nbad = 0;
        for (int k = 1; k < TRC; k++) begin
            if (!sched_busy) nbad++;
            step();
        end
        if (!sched_busy) nbad++;
        step();
        chk("R5 busy held TRC cycles", nbad, 0);
        chk("R5 busy released", int'(sched_busy), 0);
        chk("R4 one debt removed", int'({ref_urgent, ref_req}), 1);
        step();
        step();
        chk("R3 still no command without grant", int'(pins()), int'(P_NOP));

        // R4 granted refresh
        arb_grant = 1'b1;
        step();
        arb_grant = 1'b0;
        chk("R4 granted refresh", int'(pins()), int'(P_REF));
        repeat (TRC) step();

        // R6 / R7 precharge-all, then wait for idle banks
        banks_idle = 1'b0;
        arb_grant = 1'b1;
        step();
        arb_grant = 1'b0;
        chk("R6 precharge-all code", int'(pins()), int'(P_PREA));
        nbad = 0;
        for (int k = 0; k < 5; k++) begin
            step();
            if (pins() != P_NOP || !sched_busy) nbad++;
        end
        chk("R7 refresh withheld", nbad, 0);
        banks_idle = 1'b1;
        step();
        chk("R7 refresh after idle", int'(pins()), int'(P_REF));
        repeat (TRC) step();
        chk("R4 debt cleared", int'({ref_req, sched_busy}), 0);

        // R2 / R4 grant delay sweep
        for (int d = 0; d < 4; d++) begin
            wait_req(2 * IV);
            chk("R2 interval phase", pc % IV, 0);
            nbad = 0;
            for (int k = 0; k < d; k++) begin
                step();
                if (pins() != P_NOP) nbad++;
            end
            arb_grant = 1'b1;
            step();
            arb_grant = 1'b0;
            chk("R4 refresh after delayed grant", int'({pins(), nbad[0]}), int'({P_REF, 1'b0}));
            repeat (TRC) step();
        end

        // R8 / R9 self refresh entry and residence
        sleep_req = 1'b1;
        arb_grant = 1'b1;
        step();
        sleep_req = 1'b0;
        arb_grant = 1'b0;
        chk("R8 entry code with cke low", int'({pins(), sdr_cke}), int'({P_REF, 1'b0}));
        nbad = 0;
        for (int k = 0; k < 3 * IV + 5; k++) begin
            step();
            if (sdr_cke || pins() != P_DESEL || ref_req || ref_urgent || !sched_busy) nbad++;
        end
        chk("R9 self refresh held", nbad, 0);

        // R10 exit sequence
        wake_req = 1'b1;
        step();
        wake_req = 1'b0;
        pc = 0;
        chk("R10 wake nop cke high", int'({pins(), sdr_cke, sched_busy}), int'({P_NOP, 2'b11}));
        nbad = 0;
        for (int k = 1; k < TRC; k++) begin
            step();
            if (pins() != P_NOP || !sdr_cke || !sched_busy) nbad++;
        end
        chk("R10 hold after wake", nbad, 0);
        step();
        chk("R10 forced refresh", int'({pins(), sdr_cke}), int'({P_REF, 1'b1}));
        repeat (TRC) step();
        chk("R8 debt cleared on entry", int'({ref_req, sched_busy}), 0);
        wait_req(2 * IV);
        chk("R2 interval after wake", pc, IV);

        // R6 / R8 sleep with open banks goes through precharge-all
        sleep_req = 1'b1;
        arb_grant = 1'b1;
        banks_idle = 1'b0;
        step();
        arb_grant = 1'b0;
        chk("R6 precharge before sleep", int'(pins()), int'(P_PREA));
        step();
        chk("R7 wait keeps cke", int'({pins(), sdr_cke}), int'({P_NOP, 1'b1}));
        banks_idle = 1'b1;
        step();
        sleep_req = 1'b0;
        chk("R8 entry after precharge", int'({pins(), sdr_cke}), int'({P_REF, 1'b0}));
        step();
        wake_req = 1'b1;
        step();
        wake_req = 1'b0;
        pc = 0;
        repeat (2 * TRC) step();

        // R11 saturation: stall across several intervals, then drain
        wait_req(2 * IV);
        banks_idle = 1'b0;
        arb_grant = 1'b1;
        step();
        arb_grant = 1'b0;
        while (pc < 5 * IV + 20) step();
        chk("R11 urgent after stall", int'(ref_urgent), 1);
        banks_idle = 1'b1;
        arb_grant = 1'b1;
        nref = 0;
        for (int k = 0; k < 18; k++) begin
            step();
            if (pins() == P_REF) nref++;
        end
        arb_grant = 1'b0;
        chk("R11 refreshes to drain", nref, MAXO);
        chk("R11 debt gone", int'({ref_req, ref_urgent}), 0);

        finish_run();
    end
endmodule